// File: doc/BRIEF.md
# Floppy Controller Command and Result Sequencer

This block is the byte-level protocol engine that sits behind the data port of a floppy disk controller. The host writes an opcode byte followed by the parameter bytes that opcode needs. The block gathers them in a small buffer and executes the register-level commands in a single internal cycle. When a command has a reply, the block then hands the reply bytes back through the same port, one byte per read. The main status byte tells the host at every moment whether the port is ready, which way bytes flow, and whether a command is in progress.

The block also keeps the controller's interrupt-pending flag and the per-drive cylinder positions. A pulse from the sector-transfer engine, which lives outside this block, makes it build the seven-byte termination reply that closes a transfer. Sector data movement and DMA transfers are not part of this block.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After the synchronous reset, `msr` reads 0x80, `irq` is high, `dma_en` is high, every drive cylinder is 0, and the drive, head, lock, timing and configuration fields are 0. The `msr` bit positions are: 7 ready (request for master), 6 direction (1 means controller to host), 5 non-DMA execution, 4 command busy. Bits 3:0 are 0.
- R2: An accepted opcode byte (the first byte of a command) clears `irq` and sets the expected length to the opcode's parameter count plus one. While parameters are still awaited, `msr` reads 0x90. Once the last byte arrives, the command executes one cycle later.
- R3: A data write is taken only when `msr` bit 7 is 1 and bit 6 is 0. A data read is taken only when bits 7 and 6 are both 1. A read that is not taken returns 0x00 on `rd_data` and changes no state. A write that is not taken changes no state.
- R4: While reply bytes are pending, `msr` reads 0xD0, and each accepted read returns the next byte. Reading the last reply byte returns `msr` to 0x80. Bit 5 of `msr` is 0 in every phase.
- R5: Sense interrupt (opcode 0x08, no parameters) replies with ST0 and then the current drive's cylinder. For the first four senses after reset, ST0 is 0xC0, 0xC1, 0xC2 and 0xC3 in turn. After that, ST0 is 0x20 | head<<2 | drive.
- R6: Any interrupt raised by seek, recalibrate or a transfer stop cancels the post-reset sense replies that remain.
- R7: Specify (0x03, two parameters) sets step time = p1[7:4] and head-load time = p2[7:1], and sets `dma_en` = NOT p2[0]. It has no reply.
- R8: Seek (0x0F, two parameters) selects drive p1[1:0] and head p1[2], then raises `irq`. It moves that drive to cylinder p2 only if p2 <= MAX_CYL. Recalibrate (0x07, one parameter) selects drive p1[1:0], sets that drive's cylinder to 0, and raises `irq`. Neither command has a reply.
- R9: Version (0x10) replies 0x90. Part ID (0x18) replies 0x01. Lock (any opcode whose low seven bits are 0x14) stores opcode bit 7 as the lock flag and replies lock<<4.
- R10: Configure (0x13, three parameters) stores p2 as the configuration byte and p3 as the precompensation track. Dumpreg (0x0E) replies ten bytes in this order: cylinders of drives 0 to 3, step time, head-load<<1 | dma_en, last sector (LAST_SECT), lock<<7, configuration byte, precompensation track.
- R11: Any other opcode takes no parameters and replies the single byte 0x80.
- R12: A `xfer_stop` pulse while the block is idle (`msr` = 0x80) raises `irq` and starts a seven-byte reply: `xfer_st0` | head<<2 | drive, `xfer_st1`, `xfer_st2`, current cylinder, head, `xfer_sector`, 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data port write strobe |
| wr_data | input | 8 | Byte written to the data port |
| rd_en | input | 1 | Data port read strobe |
| rd_data | output | 8 | Reply byte, valid the cycle after an accepted read; 0x00 otherwise |
| xfer_stop | input | 1 | Transfer engine requests the termination reply |
| xfer_st0 | input | 8 | ST0 condition bits for the termination reply |
| xfer_st1 | input | 8 | ST1 for the termination reply |
| xfer_st2 | input | 8 | ST2 for the termination reply |
| xfer_sector | input | 8 | Sector number for the termination reply |
| msr | output | 8 | Main status byte |
| irq | output | 1 | Interrupt-pending flag |
| dma_en | output | 1 | DMA enable set by specify |

## Verification
The assertions check the port-level rules on every cycle. An accepted opcode byte drops the interrupt. A read that is not taken returns zero. A write during the reply phase leaves the status untouched. The last reply read returns the port to idle. A stop pulse at idle opens the reply phase with the interrupt raised. No seek writes a cylinder beyond the limit. Every new interrupt leaves the post-reset sense counter at zero. The contents of replies can only be shown by the bench's command sequences. These include the counting drive field in the post-reset senses, the order of the dumpreg bytes, the cylinder tracking across all four drives and the rejected out-of-range seek, and the stop frame built from the current drive and head.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  // Width of the drive-select field in command parameters and status bytes.
  localparam int SEL_W  = 2;
  localparam int BYTE_W = 8;

  // Status byte bit positions.
  localparam int MSR_RQM  = 7;
  localparam int MSR_DIO  = 6;
  localparam int MSR_NDMA = 5;
  localparam int MSR_BUSY = 4;

  typedef enum logic [3:0] {
    K_SPECIFY,
    K_SENSE,
    K_SEEK,
    K_RECAL,
    K_VERSION,
    K_PARTID,
    K_LOCK,
    K_CONFIG,
    K_DUMP,
    K_INVALID,
    K_STOP
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_EXEC,
    PH_RES
  } phase_e;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_seq_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_kind_e  kind,
  output logic [3:0] nparams
);

  always_comb begin
    kind    = K_INVALID;
    nparams = 4'd0;
    if (opcode[6:0] == 7'h14) begin
      kind = K_LOCK;
    end else begin
      case (opcode)
        8'h03: begin kind = K_SPECIFY; nparams = 4'd2; end
        8'h08: begin kind = K_SENSE;   nparams = 4'd0; end
        8'h0F: begin kind = K_SEEK;    nparams = 4'd2; end
        8'h07: begin kind = K_RECAL;   nparams = 4'd1; end
        8'h10: begin kind = K_VERSION; nparams = 4'd0; end
        8'h18: begin kind = K_PARTID;  nparams = 4'd0; end
        8'h13: begin kind = K_CONFIG;  nparams = 4'd3; end
        8'h0E: begin kind = K_DUMP;    nparams = 4'd0; end
        default: begin kind = K_INVALID; nparams = 4'd0; end
      endcase
    end
  end

endmodule

// File: rtl/fdc_param_buf.sv
module fdc_param_buf #(
  parameter int DEPTH    = 16,
  parameter int RD_PORTS = 3,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [RD_PORTS*AW-1:0] raddr,
  output logic [RD_PORTS*8-1:0] rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p*8 +: 8] = mem[raddr[p*AW +: AW]];
  end

endmodule

// File: rtl/fdc_drive_cyl.sv
module fdc_drive_cyl
  import fdc_seq_pkg::*;
#(
  parameter int NUM_DRV = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEL_W-1:0]     wsel,
  input  logic [7:0]           wcyl,
  input  logic [SEL_W-1:0]     rsel,
  output logic [7:0]           rcyl,
  output logic [NUM_DRV*8-1:0] cyl_all
);

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    logic [7:0] cyl_q;
    always_ff @(posedge clk) begin
      if (rst)                             cyl_q <= 8'h00;
      else if (we && wsel == SEL_W'(g))    cyl_q <= wcyl;
    end
    assign cyl_all[g*8 +: 8] = cyl_q;
  end

  always_comb begin
    rcyl = 8'h00;
    if (int'(rsel) < NUM_DRV) rcyl = cyl_all[rsel*8 +: 8];
  end

endmodule

// File: rtl/fdc_result_mux.sv
module fdc_result_mux
  import fdc_seq_pkg::*;
#(
  parameter int         NUM_DRV    = 4,
  parameter int         PW         = 4,
  parameter logic [7:0] VERSION_ID = 8'h90,
  parameter logic [7:0] PART_ID    = 8'h01,
  parameter logic [7:0] LAST_SECT  = 8'd18
) (
  input  cmd_kind_e            kind,
  input  logic [PW-1:0]        idx,
  input  logic [7:0]           st0,
  input  logic [7:0]           st1,
  input  logic [7:0]           st2,
  input  logic [7:0]           sector,
  input  logic [7:0]           cur_cyl,
  input  logic                 head,
  input  logic [NUM_DRV*8-1:0] cyl_all,
  input  logic [3:0]           srt,
  input  logic [6:0]           hlt,
  input  logic                 dma_en,
  input  logic                 lock,
  input  logic [7:0]           cfg,
  input  logic [7:0]           precomp,
  output logic [7:0]           byte_out
);

  logic [7:0] dump_cyl;

  always_comb begin
    dump_cyl = 8'h00;
    if (int'(idx) < NUM_DRV) dump_cyl = cyl_all[idx[1:0]*8 +: 8];
  end

  always_comb begin
    byte_out = 8'h00;
    case (kind)
      K_SENSE:   byte_out = (idx == '0) ? st0 : cur_cyl;
      K_VERSION: byte_out = VERSION_ID;
      K_PARTID:  byte_out = PART_ID;
      K_LOCK:    byte_out = {3'b000, lock, 4'b0000};
      K_INVALID: byte_out = 8'h80;
      K_DUMP: begin
        case (int'(idx))
          0, 1, 2, 3: byte_out = dump_cyl;
          4:          byte_out = {4'b0000, srt};
          5:          byte_out = {hlt, dma_en};
          6:          byte_out = LAST_SECT;
          7:          byte_out = {lock, 7'b0000000};
          8:          byte_out = cfg;
          9:          byte_out = precomp;
          default:    byte_out = 8'h00;
        endcase
      end
      K_STOP: begin
        case (int'(idx))
          0:       byte_out = st0;
          1:       byte_out = st1;
          2:       byte_out = st2;
          3:       byte_out = cur_cyl;
          4:       byte_out = {7'b0000000, head};
          5:       byte_out = sector;
          6:       byte_out = 8'h02;
          default: byte_out = 8'h00;
        endcase
      end
      default:   byte_out = 8'h00;
    endcase
  end

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int         NUM_DRV     = 4,
  parameter int         BUF_DEPTH   = 16,
  parameter logic [7:0] MAX_CYL     = 8'd79,
  parameter logic [7:0] LAST_SECT   = 8'd18,
  parameter logic [7:0] VERSION_ID  = 8'h90,
  parameter logic [7:0] PART_ID     = 8'h01,
  parameter int         RESET_SENSE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       xfer_stop,
  input  logic [7:0] xfer_st0,
  input  logic [7:0] xfer_st1,
  input  logic [7:0] xfer_st2,
  input  logic [7:0] xfer_sector,
  output logic [7:0] msr,
  output logic       irq,
  output logic       dma_en
);

  localparam int PW      = $clog2(BUF_DEPTH);
  localparam int CW      = $clog2(RESET_SENSE + 1);
  localparam int RD_PORT = 3;

  localparam logic [PW-1:0] LEN_SENSE = PW'(2);
  localparam logic [PW-1:0] LEN_ONE   = PW'(1);
  localparam logic [PW-1:0] LEN_DUMP  = PW'(10);
  localparam logic [PW-1:0] LEN_STOP  = PW'(7);

  phase_e           phase;
  logic [PW-1:0]    pos;
  logic [PW-1:0]    len;
  cmd_kind_e        kind_q;
  logic             lock_op;
  logic [SEL_W-1:0] cur_drv;
  logic             head;
  logic             irq_q;
  logic [CW-1:0]    sense_cnt;
  logic [3:0]       srt;
  logic [6:0]       hlt;
  logic             dma_q;
  logic             lock_q;
  logic [7:0]       cfg;
  logic [7:0]       precomp;
  logic [7:0]       res_st0;
  logic [7:0]       res_st1;
  logic [7:0]       res_st2;
  logic [7:0]       res_sec;
  logic [7:0]       rd_q;

  cmd_kind_e        dec_kind;
  logic [3:0]       dec_np;
  logic [RD_PORT*8-1:0] prm;
  logic [7:0]       p1, p2, p3;
  logic [7:0]       cur_cyl;
  logic [NUM_DRV*8-1:0] cyl_all;
  logic             cyl_we;
  logic [7:0]       cyl_wdata;
  logic [7:0]       res_byte;
  logic [7:0]       sense_code;
  logic             stop_take, wr_ok, rd_ok;
  logic             unused_bits;

  fdc_cmd_decode u_dec (
    .opcode  (wr_data),
    .kind    (dec_kind),
    .nparams (dec_np)
  );

  fdc_param_buf #(.DEPTH(BUF_DEPTH), .RD_PORTS(RD_PORT)) u_buf (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (pos),
    .wdata (wr_data),
    .raddr ({PW'(3), PW'(2), PW'(1)}),
    .rdata (prm)
  );

  assign p1 = prm[0  +: 8];
  assign p2 = prm[8  +: 8];
  assign p3 = prm[16 +: 8];
  assign unused_bits = p1[3];

  // Cylinder updates happen in the execute cycle of seek and recalibrate.
  assign cyl_we    = (phase == PH_EXEC) &&
                     ((kind_q == K_RECAL) || (kind_q == K_SEEK && p2 <= MAX_CYL));
  assign cyl_wdata = (kind_q == K_RECAL) ? 8'h00 : p2;

  fdc_drive_cyl #(.NUM_DRV(NUM_DRV)) u_cyl (
    .clk     (clk),
    .rst     (rst),
    .we      (cyl_we),
    .wsel    (p1[SEL_W-1:0]),
    .wcyl    (cyl_wdata),
    .rsel    (cur_drv),
    .rcyl    (cur_cyl),
    .cyl_all (cyl_all)
  );

  fdc_result_mux #(
    .NUM_DRV(NUM_DRV), .PW(PW), .VERSION_ID(VERSION_ID),
    .PART_ID(PART_ID), .LAST_SECT(LAST_SECT)
  ) u_res (
    .kind     (kind_q),
    .idx      (pos),
    .st0      (res_st0),
    .st1      (res_st1),
    .st2      (res_st2),
    .sector   (res_sec),
    .cur_cyl  (cur_cyl),
    .head     (head),
    .cyl_all  (cyl_all),
    .srt      (srt),
    .hlt      (hlt),
    .dma_en   (dma_q),
    .lock     (lock_q),
    .cfg      (cfg),
    .precomp  (precomp),
    .byte_out (res_byte)
  );

  assign stop_take = xfer_stop && (phase == PH_CMD) && (pos == '0);
  assign wr_ok     = wr_en && (phase == PH_CMD) && !stop_take;
  assign rd_ok     = rd_en && (phase == PH_RES);

  assign sense_code = (sense_cnt != '0)
                    ? 8'(8'hC0 + 8'(RESET_SENSE) - 8'(sense_cnt))
                    : {2'b00, 1'b1, 2'b00, head, cur_drv};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      pos       <= '0;
      len       <= '0;
      kind_q    <= K_INVALID;
      lock_op   <= 1'b0;
      cur_drv   <= '0;
      head      <= 1'b0;
      irq_q     <= 1'b1;
      sense_cnt <= CW'(RESET_SENSE);
      srt       <= 4'h0;
      hlt       <= 7'h00;
      dma_q     <= 1'b1;
      lock_q    <= 1'b0;
      cfg       <= 8'h00;
      precomp   <= 8'h00;
      res_st0   <= 8'h00;
      res_st1   <= 8'h00;
      res_st2   <= 8'h00;
      res_sec   <= 8'h00;
      rd_q      <= 8'h00;
    end else begin
      rd_q <= 8'h00;
      if (stop_take) begin
        res_st0   <= xfer_st0 | {5'b00000, head, cur_drv};
        res_st1   <= xfer_st1;
        res_st2   <= xfer_st2;
        res_sec   <= xfer_sector;
        kind_q    <= K_STOP;
        len       <= LEN_STOP;
        pos       <= '0;
        phase     <= PH_RES;
        irq_q     <= 1'b1;
        sense_cnt <= '0;
      end else if (wr_ok) begin
        if (pos == '0) begin
          irq_q   <= 1'b0;
          kind_q  <= dec_kind;
          lock_op <= wr_data[7];
          len     <= PW'(dec_np + 4'd1);
          if (dec_np == 4'd0) phase <= PH_EXEC;
          else                pos   <= PW'(1);
        end else if (pos == len - PW'(1)) begin
          phase <= PH_EXEC;
          pos   <= '0;
        end else begin
          pos <= pos + PW'(1);
        end
      end else if (phase == PH_EXEC) begin
        pos <= '0;
        case (kind_q)
          K_SPECIFY: begin
            srt   <= p1[7:4];
            hlt   <= p2[7:1];
            dma_q <= ~p2[0];
            phase <= PH_CMD;
          end
          K_SENSE: begin
            res_st0 <= sense_code;
            if (sense_cnt != '0) sense_cnt <= sense_cnt - CW'(1);
            len   <= LEN_SENSE;
            phase <= PH_RES;
          end
          K_SEEK: begin
            cur_drv   <= p1[SEL_W-1:0];
            head      <= p1[2];
            irq_q     <= 1'b1;
            sense_cnt <= '0;
            phase     <= PH_CMD;
          end
          K_RECAL: begin
            cur_drv   <= p1[SEL_W-1:0];
            irq_q     <= 1'b1;
            sense_cnt <= '0;
            phase     <= PH_CMD;
          end
          K_LOCK: begin
            lock_q <= lock_op;
            len    <= LEN_ONE;
            phase  <= PH_RES;
          end
          K_CONFIG: begin
            cfg     <= p2;
            precomp <= p3;
            phase   <= PH_CMD;
          end
          K_DUMP: begin
            len   <= LEN_DUMP;
            phase <= PH_RES;
          end
          K_VERSION, K_PARTID, K_INVALID: begin
            len   <= LEN_ONE;
            phase <= PH_RES;
          end
          default: phase <= PH_CMD;
        endcase
      end else if (rd_ok) begin
        rd_q <= res_byte;
        if (pos == len - PW'(1)) begin
          phase <= PH_CMD;
          pos   <= '0;
        end else begin
          pos <= pos + PW'(1);
        end
      end
    end
  end

  always_comb begin
    msr           = 8'h00;
    msr[MSR_RQM]  = (phase != PH_EXEC);
    msr[MSR_DIO]  = (phase == PH_RES);
    msr[MSR_NDMA] = 1'b0;
    msr[MSR_BUSY] = (phase != PH_CMD) || (pos != '0);
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;
  assign dma_en  = dma_q;

endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk #(
  parameter int         PW      = 4,
  parameter int         CW      = 3,
  parameter logic [7:0] MAX_CYL = 8'd79
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          xfer_stop,
  input logic [7:0]    msr,
  input logic          irq,
  input logic [7:0]    rd_data,
  input logic [PW-1:0] pos,
  input logic [PW-1:0] len,
  input logic          cyl_we,
  input logic [7:0]    cyl_wdata,
  input logic [CW-1:0] sense_cnt
);

  AST_OPCODE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && msr == 8'h80 && !xfer_stop) |=> !irq);  // R2

  AST_IGNORED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !msr[6]) |=> (rd_data == 8'h00));  // R3

  AST_WRITE_IN_REPLY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && msr[6]) |=> $stable(msr));  // R3

  AST_LAST_READ_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && msr[6] && pos == len - PW'(1)) |=> (msr == 8'h80));  // R4

  AST_NEW_IRQ_CANCELS_SENSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (sense_cnt == '0));  // R6

  AST_SEEK_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cyl_we |-> (cyl_wdata <= MAX_CYL));  // R8

  AST_STOP_OPENS_REPLY: assert property (@(posedge clk) disable iff (rst)
    (xfer_stop && msr == 8'h80) |=> (irq && msr == 8'hD0));  // R12

endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk #(.PW(PW), .CW(CW), .MAX_CYL(MAX_CYL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .xfer_stop (xfer_stop),
  .msr       (msr),
  .irq       (irq),
  .rd_data   (rd_data),
  .pos       (pos),
  .len       (len),
  .cyl_we    (cyl_we),
  .cyl_wdata (cyl_wdata),
  .sense_cnt (sense_cnt)
);

// File: tb/fdc_cmd_seq_bench.sv
module fdc_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       xfer_stop = 1'b0;
  logic [7:0] xfer_st0 = 8'h00;
  logic [7:0] xfer_st1 = 8'h00;
  logic [7:0] xfer_st2 = 8'h00;
  logic [7:0] xfer_sector = 8'h00;
  logic [7:0] msr;
  logic       irq;
  logic       dma_en;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  int         m_cyl [4];
  logic [7:0] b;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_cmd_seq u_fdc_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .xfer_stop(xfer_stop), .xfer_st0(xfer_st0),
    .xfer_st1(xfer_st1), .xfer_st2(xfer_st2), .xfer_sector(xfer_sector),
    .msr(msr), .irq(irq), .dma_en(dma_en)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
    tick();
  endtask

  task automatic rd(output logic [7:0] d);
    rd_en = 1'b1;
    tick();
    d = rd_data;
    rd_en = 1'b0;
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    for (int i = 0; i < 4; i++) m_cyl[i] = 0;
  endtask

  task automatic sense(input string tag, input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] r;
    wr(8'h08);
    chk({tag, " msr in reply"}, msr, 8'hD0);
    rd(r); chk({tag, " st0"}, r, e0);
    rd(r); chk({tag, " cylinder"}, r, e1);
    chk({tag, " msr back idle"}, msr, 8'h80);
  endtask

  task automatic dump(input string tag, input logic [7:0] e [10]);
    logic [7:0] r;
    wr(8'h0E);
    for (int i = 0; i < 10; i++) begin
      rd(r);
      chk($sformatf("%s byte %0d", tag, i), r, e[i]);
    end
    chk({tag, " msr idle"}, msr, 8'h80);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] e [10];
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 msr", msr, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h01);
    chk("R1 dma_en", {7'b0, dma_en}, 8'h01);

    // R3 read in command phase ignored
    rd(b);
    chk("R3 idle read data", b, 8'h00);
    chk("R3 idle read msr", msr, 8'h80);

    // R5 four post-reset senses with counting drive field; R2 irq clears
    wr(8'h08);
    chk("R2 opcode clears irq", {7'b0, irq}, 8'h00);
    rd(b); chk("R5 sense0 st0", b, 8'hC0);
    rd(b); chk("R5 sense0 cyl", b, 8'h00);
    for (int i = 1; i < 4; i++) sense($sformatf("R5 sense%0d", i), 8'hC0 + 8'(i), 8'h00);
    sense("R5 normal sense", 8'h20, 8'h00);

    // R9 identity and lock
    wr(8'h10); rd(b); chk("R9 version", b, 8'h90);
    wr(8'h18); rd(b); chk("R9 part id", b, 8'h01);
    wr(8'h94); rd(b); chk("R9 lock set", b, 8'h10);
    wr(8'h14); rd(b); chk("R9 lock clear", b, 8'h00);
    wr(8'h94); rd(b); chk("R9 lock set again", b, 8'h10);

    // R11 unknown opcodes
    foreach (e[i]) e[i] = 8'h00;
    begin
      logic [7:0] bad [5] = '{8'h00, 8'h01, 8'h1F, 8'hFF, 8'h55};
      foreach (bad[i]) begin
        wr(bad[i]);
        chk($sformatf("R11 op %02h msr", bad[i]), msr, 8'hD0);
        rd(b);
        chk($sformatf("R11 op %02h reply", bad[i]), b, 8'h80);
        chk($sformatf("R11 op %02h idle", bad[i]), msr, 8'h80);
      end
    end

    // R7 specify, R2 busy while collecting
    wr(8'h03); chk("R2 busy after opcode", msr, 8'h90);
    wr(8'hA0); chk("R2 busy after p1", msr, 8'h90);
    wr(8'h13); chk("R7 no reply", msr, 8'h80);
    chk("R7 dma_en cleared", {7'b0, dma_en}, 8'h00);

    // R10 configure then dumpreg
    wr(8'h13); wr(8'h00); wr(8'h57); wr(8'h21);
    chk("R10 configure no reply", msr, 8'h80);
    e = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h12, 8'd18, 8'h80, 8'h57, 8'h21};
    dump("R10 dump", e);

    // R8 seek sweep on every drive
    for (int d = 0; d < 4; d++) begin
      int h = d & 1;
      int c = 10 * d + 5;
      wr(8'h0F); wr(8'((h << 2) | d)); wr(8'(c));
      m_cyl[d] = c;
      chk($sformatf("R8 seek drive %0d irq", d), {7'b0, irq}, 8'h01);
      sense($sformatf("R8 seek drive %0d sense", d), 8'(8'h20 | (h << 2) | d), 8'(c));
    end

    // R8 out-of-range seek keeps the cylinder
    wr(8'h0F); wr(8'h05); wr(8'd80);
    chk("R8 far seek irq", {7'b0, irq}, 8'h01);
    sense("R8 far seek sense", 8'h25, 8'(m_cyl[1]));

    // R8 recalibrate drive 2 (head stays 1)
    wr(8'h07); wr(8'h02);
    m_cyl[2] = 0;
    chk("R8 recal irq", {7'b0, irq}, 8'h01);
    sense("R8 recal sense", 8'h26, 8'h00);
    e = '{8'(m_cyl[0]), 8'(m_cyl[1]), 8'(m_cyl[2]), 8'(m_cyl[3]),
          8'h0A, 8'h12, 8'd18, 8'h80, 8'h57, 8'h21};
    dump("R10 dump cylinders", e);

    // R3 write during reply ignored
    wr(8'h10);
    wr(8'h08);
    chk("R3 write in reply msr", msr, 8'hD0);
    rd(b); chk("R3 reply intact", b, 8'h90);
    chk("R3 back idle", msr, 8'h80);

    // R3 read while collecting parameters ignored
    wr(8'h03);
    rd(b);
    chk("R3 read in collect data", b, 8'h00);
    chk("R3 read in collect msr", msr, 8'h90);
    wr(8'h50); wr(8'h00);
    chk("R7 dma_en set", {7'b0, dma_en}, 8'h01);

    // R12 termination frame (drive 2, head 1)
    xfer_st0 = 8'h40; xfer_st1 = 8'h04; xfer_st2 = 8'h01; xfer_sector = 8'd7;
    xfer_stop = 1'b1;
    tick();
    xfer_stop = 1'b0;
    chk("R12 msr reply", msr, 8'hD0);
    chk("R12 irq", {7'b0, irq}, 8'h01);
    begin
      logic [7:0] f [7] = '{8'h46, 8'h04, 8'h01, 8'h00, 8'h01, 8'd7, 8'h02};
      for (int i = 0; i < 7; i++) begin
        rd(b);
        chk($sformatf("R12 frame byte %0d", i), b, f[i]);
      end
    end
    chk("R4 idle after frame", msr, 8'h80);

    // R6 interrupt cancels remaining post-reset senses
    do_reset();
    chk("R1 irq after reset", {7'b0, irq}, 8'h01);
    wr(8'h0F); wr(8'h00); wr(8'd3);
    sense("R6 sense after seek", 8'h20, 8'd3);

    finish_run();
  end

endmodule